// File: doc/BRIEF.md
# Serial Flash Continuous-Read Decoder

This block is the device-side front end of a serial NOR flash. A fast system clock oversamples chip select, the serial clock and four data lines. The block accepts the host in SPI mode 0 or mode 3. A transaction begins with an 8-bit instruction on line IO0. For a recognized multi-line read, the 24-bit address and a mode byte follow on two or four lines. After that the block returns bytes from a small internal array, and the address advances after each byte.

The mode byte decides how the next chip-select cycle starts. If its bits 5..4 hold binary 10, the block stays in continuous-read mode. The next transaction then skips the instruction and starts directly with the address, at the same lane width. Any other value returns the block to normal mode. There is no reset pin that a host can pull, so continuous-read mode survives a host restart. A host can always leave it by clocking all-ones through the address and mode phases. This takes 8 clocks on four lines or 16 clocks on two lines, and the resulting mode byte of FFh ends the mode.

The controller has the states IDLE, CMD, ADDR, MODE, DUMMY, DATA and IGNORE.
- IDLE moves to CMD when chip select is low and continuous mode is off, or to ADDR when it is on.
- CMD moves to ADDR after 8 clocks for a read instruction, or to IGNORE for any other opcode.
- ADDR moves to MODE after its last address clock.
- MODE moves to DUMMY for quad reads or to DATA for dual reads.
- DUMMY moves to DATA after 4 clocks.
- DATA and IGNORE hold their state.
- From any state, chip select sampled high forces IDLE.

Top module: `sfc_xip_decoder`

## Requirements
- R1: After power-on reset, continuous mode is off (cont_active=0) and io_oe is 0.
- R2: The instruction is taken from IO0, MSB first, over 8 rising clocks. BBh selects dual I/O read. EBh, E7h and E3h select quad I/O read. Any other opcode, FFh included, drives no line until chip select rises.
- R3: In a quad read, the address takes 6 clocks and the mode byte 2 clocks, each on IO3..IO0 with IO3 most significant. Four dummy clocks follow. Data then appears high nibble first on IO3..IO0 with io_oe=1111, and nothing is driven before the data phase.
- R4: In a dual read, the address takes 12 clocks and the mode byte 4 clocks, each on IO1..IO0 with IO1 most significant. Data follows at once, two bits per clock with bit 7 on IO1, and io_oe=0011.
- R5: The byte at location a is (a mod 256)*37+90, taken mod 256. Bytes stream from consecutive addresses until chip select rises, and the location wraps modulo 256.
- R6: A complete mode byte with bits 5..4 = 10 sets cont_active. The next transaction then starts with the address at the width of the read that set it.
- R7: A complete mode byte with bits 5..4 other than 10 clears cont_active, and the next transaction needs an instruction again.
- R8: Mode byte bits 7..6 and 3..0 have no effect on behaviour.
- R9: In continuous mode, all-ones for 8 clocks on four lines (quad) or 16 clocks on two lines (dual) clears cont_active, and no line is driven during the sequence.
- R10: Chip select rising at any point aborts the transaction and restarts at the first phase. cont_active changes only when a mode byte completes. If chip select rises in the same sampled cycle as the mode byte's last clock, the abort wins and the flag keeps its value.
- R11: SPI mode 0 (clock idle low) and mode 3 (clock idle high) give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| io_in | input | 4 | Data lines as seen at the pins |
| io_out | output | 4 | Read data driven toward the pins |
| io_oe | output | 4 | Per-line output enable |
| cont_active | output | 1 | Continuous-read mode is latched |

## Verification
Aborting on chip select and latching the mode byte can fall in the same system-clock cycle. This happens when the host raises chip select together with the rising clock that carries the last mode-byte chunk. The bench provokes it by first entering continuous mode, then sending an address and a mode byte of 00h, and changing cs_n and sck on the same edge for the final chunk. It judges the result by checking that cont_active stays set, and that the following transaction still needs no instruction and returns correct data.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_MODE,
        S_DUMMY,
        S_DATA,
        S_IGNORE
    } sfc_state_e;

    localparam logic [7:0] OP_DUAL_IO   = 8'hBB;
    localparam logic [7:0] OP_QUAD_IO   = 8'hEB;
    localparam logic [7:0] OP_QUAD_WORD = 8'hE7;
    localparam logic [7:0] OP_QUAD_OCT  = 8'hE3;
    localparam logic [1:0] CONT_KEY     = 2'b10;

    function automatic logic op_is_quad(input logic [7:0] op);
        return (op == OP_QUAD_IO) || (op == OP_QUAD_WORD) || (op == OP_QUAD_OCT);
    endfunction

    function automatic logic op_is_dual(input logic [7:0] op);
        return op == OP_DUAL_IO;
    endfunction
endpackage

// File: rtl/sfc_pin_sampler.sv
module sfc_pin_sampler #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [LANES-1:0] io_in,
    output logic             cs_q,
    output logic [LANES-1:0] io_q,
    output logic             sck_rise,
    output logic             sck_fall
);
    logic sck_q, sck_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            sck_p <= 1'b0;
            io_q  <= '0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            sck_p <= sck_q;
            io_q  <= io_in;
        end
    end

    assign sck_rise = sck_q & ~sck_p;
    assign sck_fall = ~sck_q & sck_p;
endmodule

// File: rtl/sfc_array.sv
module sfc_array #(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int MUL = 37,
    parameter int OFS = 90
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = DW'(i * MUL + OFS);
    end

    assign data = cells[addr];
endmodule

// File: rtl/sfc_serializer.sv
module sfc_serializer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          shift_en,
    input  logic          quad,
    input  logic [DW-1:0] byte_in,
    output logic [3:0]    lanes_out,
    output logic          take
);
    localparam int BEATS_Q = DW / 4;
    localparam int BEATS_D = DW / 2;
    localparam int BW      = $clog2(BEATS_D);

    logic [BW-1:0] beat_q;
    logic [BW-1:0] last_beat;
    logic [DW-1:0] dsh_q;
    logic [DW-1:0] src;

    assign last_beat = quad ? BW'(BEATS_Q - 1) : BW'(BEATS_D - 1);
    assign take      = active && shift_en && (beat_q == '0);
    assign src       = (beat_q == '0) ? byte_in : dsh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q    <= '0;
            dsh_q     <= '0;
            lanes_out <= '0;
        end else if (!active) begin
            beat_q    <= '0;
            dsh_q     <= '0;
            lanes_out <= '0;
        end else if (shift_en) begin
            lanes_out <= quad ? src[DW-1:DW-4] : {2'b00, src[DW-1:DW-2]};
            dsh_q     <= quad ? (src << 4) : (src << 2);
            beat_q    <= (beat_q == last_beat) ? '0 : beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/sfc_xip_decoder.sv
module sfc_xip_decoder
    import sfc_pkg::*;
#(
    parameter int ADDR_BITS  = 24,
    parameter int MEM_AW     = 8,
    parameter int QUAD_DUMMY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       cont_active
);
    localparam int CNT_W      = $clog2(ADDR_BITS);
    localparam int ADDR_CLK_Q = ADDR_BITS / 4;
    localparam int ADDR_CLK_D = ADDR_BITS / 2;
    localparam int MODE_CLK_Q = 2;
    localparam int MODE_CLK_D = 4;

    logic             cs_q, sck_rise, sck_fall;
    logic [3:0]       io_q;
    sfc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [ADDR_BITS-1:0] sh_q, sh_nx;
    logic [MEM_AW-1:0]    addr_q;
    logic             quad_q, cont_q;
    logic             phase_last, step, take;
    logic [7:0]       op_nx, rd_byte;

    sfc_pin_sampler #(.LANES(4)) sampler_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_in(io_in),
        .cs_q(cs_q), .io_q(io_q), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    sfc_array #(.AW(MEM_AW), .DW(8)) array_i (
        .addr(addr_q), .data(rd_byte)
    );

    sfc_serializer #(.DW(8)) ser_i (
        .clk(clk), .rst_n(rst_n),
        .active(state_q == S_DATA && !cs_q),
        .shift_en(sck_fall), .quad(quad_q), .byte_in(rd_byte),
        .lanes_out(io_out), .take(take)
    );

    // Incoming bits: single line for the opcode, else two or four lines MSB first
    always_comb begin
        if (state_q == S_CMD)
            sh_nx = {sh_q[ADDR_BITS-2:0], io_q[0]};
        else if (quad_q)
            sh_nx = {sh_q[ADDR_BITS-5:0], io_q};
        else
            sh_nx = {sh_q[ADDR_BITS-3:0], io_q[1:0]};
    end
    assign op_nx = sh_nx[7:0];

    always_comb begin
        unique case (state_q)
            S_CMD:   phase_last = (cnt_q == CNT_W'(7));
            S_ADDR:  phase_last = (cnt_q == (quad_q ? CNT_W'(ADDR_CLK_Q - 1) : CNT_W'(ADDR_CLK_D - 1)));
            S_MODE:  phase_last = (cnt_q == (quad_q ? CNT_W'(MODE_CLK_Q - 1) : CNT_W'(MODE_CLK_D - 1)));
            S_DUMMY: phase_last = (cnt_q == CNT_W'(QUAD_DUMMY - 1));
            default: phase_last = 1'b0;
        endcase
    end
    assign step = sck_rise && !cs_q && phase_last;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_q) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:   state_d = cont_q ? S_ADDR : S_CMD;
                S_CMD:    if (step) state_d = (op_is_dual(op_nx) || op_is_quad(op_nx)) ? S_ADDR : S_IGNORE;
                S_ADDR:   if (step) state_d = S_MODE;
                S_MODE:   if (step) state_d = quad_q ? S_DUMMY : S_DATA;
                S_DUMMY:  if (step) state_d = S_DATA;
                S_DATA:   state_d = S_DATA;
                S_IGNORE: state_d = S_IGNORE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            addr_q <= '0;
            quad_q <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            if (state_q != state_d || state_q == S_IDLE) cnt_q <= '0;
            else if (sck_rise) cnt_q <= cnt_q + 1'b1;

            if (sck_rise && !cs_q) sh_q <= sh_nx;

            if (state_q == S_CMD && step && (op_is_dual(op_nx) || op_is_quad(op_nx)))
                quad_q <= op_is_quad(op_nx);

            if (state_q == S_ADDR && step) addr_q <= sh_nx[MEM_AW-1:0];
            else if (take)                 addr_q <= addr_q + 1'b1;

            if (state_q == S_MODE && step) cont_q <= (sh_nx[5:4] == CONT_KEY);
        end
    end

    // Outputs
    always_comb begin
        io_oe = 4'h0;
        if (state_q == S_DATA) io_oe = quad_q ? 4'hF : 4'h3;
        cont_active = cont_q;
    end
endmodule

// File: rtl/sfc_xip_checker.sv
module sfc_xip_checker
    import sfc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_q,
    input sfc_state_e state_q,
    input logic       cont_active,
    input logic [3:0] io_oe
);
    // R10: chip select sampled high stops all driving on the next cycle
    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> (io_oe == 4'h0));

    // R3 and R4: only the quad or dual lane groups are ever enabled
    assert_lane_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'h0) || (io_oe == 4'h3) || (io_oe == 4'hF));

    // R6: the continuous flag moves only as a mode byte completes
    assert_flag_at_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cont_active) |-> ($past(state_q) == S_MODE));

    // R2: an ignored opcode never leads to driving
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IGNORE) |=> (io_oe == 4'h0));
endmodule

bind sfc_xip_decoder sfc_xip_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .state_q(state_q),
    .cont_active(cont_active), .io_oe(io_oe)
);

// File: tb/sfc_xip_decoder_tb.sv
module sfc_xip_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic [3:0] io_drv = 4'h0;
    logic [3:0] io_out, io_oe;
    logic       cont_active;

    int  checks = 0;
    int  fails  = 0;
    bit  mode3  = 1'b0;
    bit  model_cont = 1'b0;
    bit  model_quad = 1'b0;
    bit  done = 1'b0;
    logic [3:0] oe_acc;

    always #10 clk = ~clk;

    sfc_xip_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_in(io_drv),
        .io_out(io_out), .io_oe(io_oe), .cont_active(cont_active)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(((a % 256) * 37) + 90);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic begin_x();
        sck  = mode3;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clk1(input logic [3:0] d, output logic [3:0] o, output logic [3:0] oe);
        sck = 1'b0;
        io_drv = d;
        repeat (4) @(negedge clk);
        o  = io_out;
        oe = io_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_x();
        if (!mode3) begin
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        cs_n   = 1'b1;
        io_drv = 4'h0;
        repeat (8) @(negedge clk);
        sck = mode3;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_single(input logic [7:0] b);
        logic [3:0] o, oe;
        for (int i = 7; i >= 0; i--) begin
            clk1({3'b000, b[i]}, o, oe);
            oe_acc |= oe;
        end
    endtask

    task automatic send_wide(input logic [31:0] val, input int nbits, input bit q);
        logic [3:0] o, oe;
        int lanes = q ? 4 : 2;
        for (int c = 0; c < nbits / lanes; c++) begin
            logic [31:0] ch = (val >> (nbits - lanes * (c + 1))) & (q ? 32'hF : 32'h3);
            clk1(ch[3:0], o, oe);
            oe_acc |= oe;
        end
    endtask

    task automatic do_read(input bit with_cmd, input logic [7:0] op, input bit q,
                           input int addr, input logic [7:0] m, input int nbytes, input string req);
        logic [3:0] o, oe;
        int lanes = q ? 4 : 2;
        int bad_oe = 0;
        begin_x();
        oe_acc = 4'h0;
        if (with_cmd) send_single(op);
        send_wide(32'(addr), 24, q);
        send_wide({24'h0, m}, 8, q);
        if (q) for (int i = 0; i < 4; i++) begin clk1(4'h0, o, oe); oe_acc |= oe; end
        chk(oe_acc == 4'h0, req, "lines driven before data", int'(oe_acc), 0);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got = 8'h0;
            for (int c = 0; c < 8 / lanes; c++) begin
                clk1(4'h0, o, oe);
                got = q ? {got[3:0], o} : {got[5:0], o[1:0]};
                if (oe != (q ? 4'hF : 4'h3)) bad_oe++;
            end
            chk(got == pat(addr + b), req, "read byte", int'(got), int'(pat(addr + b)));
            chk(bad_oe == 0, q ? "R3" : "R4", "output enable during data", bad_oe, 0);
        end
        end_x();
        model_cont = (m[5:4] == 2'b10);
        model_quad = q;
        chk(cont_active == model_cont, req, "continuous flag after read", int'(cont_active), int'(model_cont));
    endtask

    task automatic all_ones(input int nclk, input bit q);
        logic [3:0] o, oe;
        begin_x();
        oe_acc = 4'h0;
        for (int i = 0; i < nclk; i++) begin
            clk1(q ? 4'hF : 4'h3, o, oe);
            oe_acc |= oe;
        end
        end_x();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] o, oe;
        logic [7:0] qops [3];
        qops[0] = 8'hEB; qops[1] = 8'hE7; qops[2] = 8'hE3;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cont_active == 1'b0, "R1", "flag after reset", int'(cont_active), 0);
        chk(io_oe == 4'h0, "R1", "oe after reset", int'(io_oe), 0);

        // R2: unsupported opcode 03h ignored
        begin_x();
        oe_acc = 4'h0;
        send_single(8'h03);
        for (int i = 0; i < 16; i++) begin clk1(4'h5, o, oe); oe_acc |= oe; end
        end_x();
        chk(oe_acc == 4'h0, "R2", "unsupported opcode drove lines", int'(oe_acc), 0);

        // R5: wrap at the top of the array; R6: enter continuous quad
        do_read(1'b1, 8'hE7, 1'b1, 32'h0000FF, 8'h20, 3, "R5");
        // R8: reserved bits set, still continuous, no instruction
        do_read(1'b0, 8'h00, 1'b1, 32'h123456, 8'hEF, 2, "R8");

        // R10: abort mid-address keeps the flag
        begin_x();
        send_wide(32'h000ABC, 12, 1'b1);
        end_x();
        chk(cont_active == 1'b1, "R10", "flag after aborted address", int'(cont_active), 1);

        // R9: quad all-ones release
        all_ones(8, 1'b1);
        model_cont = 1'b0;
        chk(cont_active == 1'b0, "R9", "flag after quad release", int'(cont_active), 0);
        chk(oe_acc == 4'h0, "R9", "driven during quad release", int'(oe_acc), 0);

        // R4 + R6: dual continuous, then R9 dual release
        do_read(1'b1, 8'hBB, 1'b0, 32'h00F0FE, 8'h2F, 3, "R4");
        do_read(1'b0, 8'h00, 1'b0, 32'h000010, 8'hA1, 2, "R6");
        all_ones(16, 1'b0);
        model_cont = 1'b0;
        chk(cont_active == 1'b0, "R9", "flag after dual release", int'(cont_active), 0);
        chk(oe_acc == 4'h0, "R9", "driven during dual release", int'(oe_acc), 0);

        // R2/R9: FFh in normal mode is just an unknown opcode
        begin_x();
        oe_acc = 4'h0;
        send_single(8'hFF);
        for (int i = 0; i < 8; i++) begin clk1(4'hF, o, oe); oe_acc |= oe; end
        end_x();
        chk(oe_acc == 4'h0, "R2", "FFh in normal mode drove lines", int'(oe_acc), 0);
        chk(cont_active == 1'b0, "R9", "flag after FFh in normal mode", int'(cont_active), 0);

        // R11: mode 3, dual read leaving normal mode
        mode3 = 1'b1;
        do_read(1'b1, 8'hBB, 1'b0, 32'h000033, 8'h10, 2, "R11");
        do_read(1'b1, 8'hEB, 1'b1, 32'h000077, 8'h20, 2, "R11");
        mode3 = 1'b0;
        // R7: clear from continuous
        do_read(1'b0, 8'h00, 1'b1, 32'h000001, 8'h30, 1, "R7");
        do_read(1'b1, 8'hEB, 1'b1, 32'h000040, 8'h20, 1, "R6");

        // R10: chip select rises with the last mode clock
        begin_x();
        send_wide(32'h000099, 24, 1'b1);
        clk1(4'h0, o, oe);
        sck = 1'b0;
        io_drv = 4'h0;
        repeat (4) @(negedge clk);
        sck  = 1'b1;
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
        repeat (2) @(negedge clk);
        chk(cont_active == 1'b1, "R10", "flag after same-cycle abort", int'(cont_active), 1);
        do_read(1'b0, 8'h00, 1'b1, 32'h0000C8, 8'h20, 2, "R10");

        // Random mix: R3 R4 R5 R6 R7 R8 R11
        for (int n = 0; n < 40; n++) begin
            bit q;
            logic [7:0] op, m;
            int a, nb;
            mode3 = 1'($urandom % 2);
            q  = model_cont ? model_quad : 1'($urandom % 2);
            op = q ? qops[$urandom % 3] : 8'hBB;
            a  = int'($urandom & 32'hFFFFFF);
            m  = 8'($urandom);
            if ($urandom % 2 == 0) m[5:4] = 2'b10;
            nb = 1 + int'($urandom % 4);
            do_read(!model_cont, op, q, a, m, nb, q ? "R3" : "R4");
        end
        mode3 = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule